// File: doc/BRIEF.md
# Biased Test-Pattern Source

This block produces one test vector per enabled clock in which each bit comes out 1 with a probability chosen for that bit. An unbiased vector gives a 1 half the time. That is a poor stimulus for logic such as a wide AND gate, whose output stuck-at-0 fault is exercised by only one pattern in 2^8 when the gate has eight inputs. A maximal-length shift register provides equiprobable raw bits. Each output bit owns a private group of four raw bits. A two-bit weight code chooses how many bits of that group are ANDed, and an invert bit complements the result. A bit can therefore be a 1 with probability 1/2, 1/4, 1/8 or 1/16, or with probability 1/2, 3/4, 7/8 or 15/16 when inverted.

Several complete weight configurations are held in a small bank, because a circuit under test usually needs two or three of them. Software or a test controller writes the bank slots. It then starts a pattern run by loading a seed, and the same seed load selects which slot drives the run.

Top module: `biased_pattern_gen`

## Requirements
- R1: After reset the pattern output is all zeros, the shift register holds the default seed (16'hBBBB at the default size), slot 0 is active, and every slot holds weight code 0 with invert 0 for every bit.
- R2: The shift register is 4×NUM_OUT bits wide. On each enabled step it shifts toward its MSB, and bit 0 takes the XOR of bits 15, 14, 12 and 3 at the default width of 16. It never holds zero and returns to its start state after exactly 2^16−1 steps.
- R3: On an enabled step, output bit i becomes the AND of shift-register bits 4i through 4i+w, taken from the state before the step, XOR the bit's invert flag. Here w is the weight code at cfg_wsel bits [2i+1:2i] of the active slot and the invert flag is bit i of cfg_inv. Code 0 gives 1/2, code 1 gives 1/4, code 2 gives 1/8 and code 3 gives 1/16.
- R4: seed_load writes seed_val into the shift register, and an all-zero seed_val loads the default seed instead. seed_load wins over step_en, and the pattern output does not change in a load cycle.
- R5: seed_load latches set_sel as the active slot. At any other time set_sel has no effect.
- R6: cfg_we writes cfg_wsel and cfg_inv into slot cfg_slot. A write to the active slot takes effect from the next step and changes neither the pattern nor the shift register.
- R7: With step_en low, the pattern output and the shift register both hold.
- R8: Over one full period from any seed, a bit with code 3 and no invert is 1 in exactly 4096 steps. A bit with code 2 and no invert is 1 in 8192 steps. A bit with code 0 inverted is 1 in 32767 steps, and a bit with code 1 inverted is 1 in 49151 steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seed_load | input | 1 | Load seed and latch active slot |
| seed_val | input | 4*NUM_OUT | Seed value, zero selects default |
| step_en | input | 1 | Advance one pattern |
| set_sel | input | SLOT_W | Slot to activate on seed_load |
| cfg_we | input | 1 | Write enable for weight bank |
| cfg_slot | input | SLOT_W | Slot written by cfg_we |
| cfg_wsel | input | 2*NUM_OUT | Two-bit weight code per output bit |
| cfg_inv | input | NUM_OUT | Invert flag per output bit |
| pattern | output | NUM_OUT | Weighted test vector |

## Verification
The exact bias counts are the hardest property to reach from the ports. They only hold when the generator is walked through every state of its period. The stimulus therefore loads a seed, holds step_en high for all 65535 steps, and tallies the ones on each output. Four different weight and invert settings are active on the four bits during that run. One further step then shows that the sequence has wrapped back to the seed.

// File: rtl/bpg_pkg.sv
// Shared helpers for the biased pattern generator.
// Assumes shift-register widths that are multiples of 4 between 8 and 32.
package bpg_pkg;

    // Feedback tap mask (bit t-1 set for tap t) of a maximal-length polynomial
    function automatic logic [31:0] tap_mask(input int unsigned width);
        case (width)
            8:       tap_mask = 32'h0000_00B8;
            12:      tap_mask = 32'h0000_0829;
            16:      tap_mask = 32'h0000_D008;
            20:      tap_mask = 32'h0009_0000;
            24:      tap_mask = 32'h00E1_0000;
            28:      tap_mask = 32'h0900_0000;
            32:      tap_mask = 32'h8020_0003;
            default: tap_mask = 32'h0000_0000;
        endcase
    endfunction

endpackage

// File: rtl/bpg_lfsr.sv
// Fibonacci shift register that supplies equiprobable raw bits.
// A load has priority over a step. A zero seed is replaced by DEFAULT_SEED so
// the register never locks up.
module bpg_lfsr #(
    parameter int unsigned         WIDTH        = 16,
    parameter logic [WIDTH-1:0]    DEFAULT_SEED = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] seed,
    input  logic             step,
    output logic [WIDTH-1:0] state
);
    import bpg_pkg::*;

    localparam logic [31:0]      MASK32 = tap_mask(WIDTH);
    localparam logic [WIDTH-1:0] TAPS   = MASK32[WIDTH-1:0];

    logic             fb;
    logic [WIDTH-1:0] seed_safe;

    // Feedback bit and zero-seed substitution
    always_comb begin
        fb        = ^(state & TAPS);
        seed_safe = (seed == '0) ? DEFAULT_SEED : seed;
    end

    // State register: reset, load or shift
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= DEFAULT_SEED;
        end else if (load) begin
            state <= seed_safe;
        end else if (step) begin
            state <= {state[WIDTH-2:0], fb};
        end
    end

endmodule

// File: rtl/bpg_weight_bank.sv
// Bank of weight configurations. Each slot holds a 2-bit weight code and an
// invert flag per output bit. Read is combinational and write is synchronous.
// Assumes NUM_SETS is a power of two, so every slot index is valid.
module bpg_weight_bank #(
    parameter int unsigned NUM_OUT  = 4,
    parameter int unsigned NUM_SETS = 4,
    localparam int unsigned SLOT_W  = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [SLOT_W-1:0]    wr_slot,
    input  logic [2*NUM_OUT-1:0] wr_wsel,
    input  logic [NUM_OUT-1:0]   wr_inv,
    input  logic [SLOT_W-1:0]    rd_slot,
    output logic [2*NUM_OUT-1:0] rd_wsel,
    output logic [NUM_OUT-1:0]   rd_inv
);
    logic [2*NUM_OUT-1:0] wsel_mem [NUM_SETS];
    logic [NUM_OUT-1:0]   inv_mem  [NUM_SETS];

    // Slot storage: cleared on reset, written on we
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                wsel_mem[s] <= '0;
                inv_mem[s]  <= '0;
            end
        end else if (we) begin
            wsel_mem[wr_slot] <= wr_wsel;
            inv_mem[wr_slot]  <= wr_inv;
        end
    end

    // Active-slot read
    always_comb begin
        rd_wsel = wsel_mem[rd_slot];
        rd_inv  = inv_mem[rd_slot];
    end

endmodule

// File: rtl/bpg_bias_cell.sv
// Biases one output bit. It ANDs the first wsel+1 bits of its private 4-bit
// group and then optionally inverts the result.
module bpg_bias_cell (
    input  logic [3:0] grp,
    input  logic [1:0] wsel,
    input  logic       inv,
    output logic       bit_o
);
    logic anded;

    // Prefix AND selected by the weight code
    always_comb begin
        case (wsel)
            2'd0:    anded = grp[0];
            2'd1:    anded = &grp[1:0];
            2'd2:    anded = &grp[2:0];
            default: anded = &grp[3:0];
        endcase
        bit_o = anded ^ inv;
    end

endmodule

// File: rtl/biased_pattern_gen.sv
// Weighted pseudo-random pattern generator top.
// Output bit i draws on shift-register bits [4i+3:4i]. The active weight slot
// is latched on seed_load, and the pattern register advances on step_en.
// Assumes NUM_OUT between 2 and 8 (register widths 8..32).
module biased_pattern_gen #(
    parameter int unsigned        NUM_OUT      = 4,
    parameter int unsigned        NUM_SETS     = 4,
    parameter logic [4*NUM_OUT-1:0] SEED_DEFAULT = {NUM_OUT{4'b1011}},
    localparam int unsigned       LFSR_W       = 4 * NUM_OUT,
    localparam int unsigned       SLOT_W       = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 seed_load,
    input  logic [LFSR_W-1:0]    seed_val,
    input  logic                 step_en,
    input  logic [SLOT_W-1:0]    set_sel,
    input  logic                 cfg_we,
    input  logic [SLOT_W-1:0]    cfg_slot,
    input  logic [2*NUM_OUT-1:0] cfg_wsel,
    input  logic [NUM_OUT-1:0]   cfg_inv,
    output logic [NUM_OUT-1:0]   pattern
);
    logic [LFSR_W-1:0]    lfsr_state;
    logic [SLOT_W-1:0]    act_slot_q;
    logic [2*NUM_OUT-1:0] act_wsel;
    logic [NUM_OUT-1:0]   act_inv;
    logic [NUM_OUT-1:0]   next_pat;
    logic                 advance;

    // A load cycle never advances the pattern
    always_comb advance = step_en && !seed_load;

    bpg_lfsr #(
        .WIDTH        (LFSR_W),
        .DEFAULT_SEED (SEED_DEFAULT)
    ) lfsr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (seed_load),
        .seed  (seed_val),
        .step  (advance),
        .state (lfsr_state)
    );

    bpg_weight_bank #(
        .NUM_OUT  (NUM_OUT),
        .NUM_SETS (NUM_SETS)
    ) bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .wr_slot (cfg_slot),
        .wr_wsel (cfg_wsel),
        .wr_inv  (cfg_inv),
        .rd_slot (act_slot_q),
        .rd_wsel (act_wsel),
        .rd_inv  (act_inv)
    );

    // One bias cell per output bit
    for (genvar i = 0; i < NUM_OUT; i++) begin : g_cell
        bpg_bias_cell cell_i (
            .grp   (lfsr_state[4*i +: 4]),
            .wsel  (act_wsel[2*i +: 2]),
            .inv   (act_inv[i]),
            .bit_o (next_pat[i])
        );
    end

    // Active slot latched at the start of a run
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_slot_q <= '0;
        end else if (seed_load) begin
            act_slot_q <= set_sel;
        end
    end

    // Pattern register updated once per enabled step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pattern <= '0;
        end else if (advance) begin
            pattern <= next_pat;
        end
    end

endmodule

// File: rtl/bpg_checker.sv
// Property checker for biased_pattern_gen. It is attached by bind and
// observes the ports plus the shift-register state and the active slot.
module bpg_checker #(
    parameter int unsigned       NUM_OUT      = 4,
    parameter int unsigned       LFSR_W       = 16,
    parameter int unsigned       SLOT_W       = 2,
    parameter logic [LFSR_W-1:0] SEED_DEFAULT = '1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               seed_load,
    input logic [LFSR_W-1:0]  seed_val,
    input logic               step_en,
    input logic [SLOT_W-1:0]  set_sel,
    input logic [NUM_OUT-1:0] pattern,
    input logic [LFSR_W-1:0]  lfsr_state,
    input logic [SLOT_W-1:0]  act_slot_q
);

    assert_lfsr_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_state != '0);

    assert_lfsr_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !seed_load) |=> lfsr_state[LFSR_W-1:1] == $past(lfsr_state[LFSR_W-2:0]));

    assert_seed_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        seed_load |=> lfsr_state == (($past(seed_val) == '0) ? SEED_DEFAULT : $past(seed_val)));

    assert_load_keeps_pattern_R4: assert property (@(posedge clk) disable iff (!rst_n)
        seed_load |=> $stable(pattern));

    assert_slot_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        seed_load |=> act_slot_q == $past(set_sel));

    assert_slot_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !seed_load |=> $stable(act_slot_q));

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && !seed_load) |=> ($stable(pattern) && $stable(lfsr_state)));

endmodule

bind biased_pattern_gen bpg_checker #(
    .NUM_OUT      (NUM_OUT),
    .LFSR_W       (LFSR_W),
    .SLOT_W       (SLOT_W),
    .SEED_DEFAULT (SEED_DEFAULT)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .seed_load  (seed_load),
    .seed_val   (seed_val),
    .step_en    (step_en),
    .set_sel    (set_sel),
    .pattern    (pattern),
    .lfsr_state (lfsr_state),
    .act_slot_q (act_slot_q)
);

// File: tb/biased_pattern_gen_tb.sv
// Self-checking bench for biased_pattern_gen at its default size.
module biased_pattern_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] DEF_SEED = 16'hBBBB;

    // Table entries are {weight codes[7:0], invert[3:0], seed[15:0]}
    localparam logic [27:0] VEC_TBL [6] = '{
        {8'h00, 4'h0, 16'h0001},
        {8'hFF, 4'h0, 16'hFFFF},
        {8'hFF, 4'hF, 16'h1234},
        {8'hE4, 4'h5, 16'hBEEF},
        {8'h1B, 4'hA, 16'h8000},
        {8'h55, 4'h3, 16'h0F0F}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seed_load = 1'b0;
    logic [15:0] seed_val = '0;
    logic        step_en = 1'b0;
    logic [1:0]  set_sel = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_slot = '0;
    logic [7:0]  cfg_wsel = '0;
    logic [3:0]  cfg_inv = '0;
    logic [3:0]  pattern;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 0;

    // Bench-side model state
    logic [15:0] m_lfsr;
    logic [7:0]  m_wsel;
    logic [3:0]  m_inv;

    biased_pattern_gen dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .seed_load (seed_load),
        .seed_val  (seed_val),
        .step_en   (step_en),
        .set_sel   (set_sel),
        .cfg_we    (cfg_we),
        .cfg_slot  (cfg_slot),
        .cfg_wsel  (cfg_wsel),
        .cfg_inv   (cfg_inv),
        .pattern   (pattern)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000 && !done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    function automatic logic [15:0] lfsr_next(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[14] ^ s[12] ^ s[3]};
    endfunction

    function automatic logic [3:0] exp_pat(input logic [15:0] s, input logic [7:0] w,
                                           input logic [3:0] inv);
        logic [3:0] r;
        for (int i = 0; i < 4; i++) begin
            logic a = 1'b1;
            for (int j = 0; j <= int'(w[2*i +: 2]); j++) a = a & s[4*i + j];
            r[i] = a ^ inv[i];
        end
        return r;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [1:0] slot, input logic [7:0] w, input logic [3:0] inv);
        @(negedge clk);
        cfg_we = 1'b1; cfg_slot = slot; cfg_wsel = w; cfg_inv = inv;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic load_seed(input logic [15:0] seed, input logic [1:0] sel);
        @(negedge clk);
        seed_load = 1'b1; seed_val = seed; set_sel = sel;
        @(negedge clk);
        seed_load = 1'b0;
        m_lfsr = (seed == '0) ? DEF_SEED : seed;
    endtask

    task automatic run_steps(input int n, input string req);
        @(negedge clk);
        step_en = 1'b1;
        for (int k = 0; k < n; k++) begin
            logic [3:0] e;
            e = exp_pat(m_lfsr, m_wsel, m_inv);
            m_lfsr = lfsr_next(m_lfsr);
            @(negedge clk);
            check(req, pattern, e);
        end
        step_en = 1'b0;
    endtask

    initial begin
        logic [3:0] held;
        int ones [4];

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 reset pattern", pattern, 0);
        rst_n = 1'b1;
        m_lfsr = DEF_SEED; m_wsel = '0; m_inv = '0;
        run_steps(4, "R1 default seed and slot 0");

        // R3 R6 R5: table of configurations through slot 1
        for (int t = 0; t < 6; t++) begin
            m_wsel = VEC_TBL[t][27:20];
            m_inv  = VEC_TBL[t][19:16];
            write_cfg(2'd1, m_wsel, m_inv);
            load_seed(VEC_TBL[t][15:0], 2'd1);
            run_steps(10, "R3 weighted bits");
        end

        // R7: idle holds pattern and register
        held = pattern;
        repeat (5) @(negedge clk);
        check("R7 idle hold", pattern, held);
        run_steps(3, "R7 register held while idle");

        // R5: set_sel without load is ignored
        write_cfg(2'd2, 8'hFF, 4'hF);
        @(negedge clk);
        set_sel = 2'd2;
        run_steps(3, "R5 set_sel ignored");
        m_wsel = 8'hFF; m_inv = 4'hF;
        load_seed(16'h0F0F, 2'd2);
        run_steps(3, "R5 slot latched on load");

        // R4: zero seed selects default
        load_seed(16'h0000, 2'd2);
        run_steps(3, "R4 zero seed");

        // R4: load beats step, pattern unchanged
        held = pattern;
        @(negedge clk);
        seed_load = 1'b1; step_en = 1'b1; seed_val = 16'h5A5A; set_sel = 2'd2;
        @(negedge clk);
        seed_load = 1'b0; step_en = 1'b0;
        check("R4 load keeps pattern", pattern, held);
        m_lfsr = 16'h5A5A;
        run_steps(3, "R4 load priority");

        // R6: writing the active slot disturbs nothing and applies next step
        held = pattern;
        m_wsel = 8'h6C; m_inv = 4'h9;
        write_cfg(2'd2, m_wsel, m_inv);
        check("R6 write keeps pattern", pattern, held);
        run_steps(4, "R6 new weights apply");

        // R8 R2: full period statistics and wrap
        m_wsel = 8'h93; m_inv = 4'b0110;
        write_cfg(2'd3, m_wsel, m_inv);
        load_seed(16'h0001, 2'd3);
        for (int i = 0; i < 4; i++) ones[i] = 0;
        @(negedge clk);
        step_en = 1'b1;
        for (int k = 0; k < 65535; k++) begin
            @(negedge clk);
            for (int i = 0; i < 4; i++) ones[i] += int'(pattern[i]);
        end
        step_en = 1'b0;
        check("R8 code3 plain ones", ones[0], 4096);
        check("R8 code0 inverted ones", ones[1], 32767);
        check("R8 code1 inverted ones", ones[2], 49151);
        check("R8 code2 plain ones", ones[3], 8192);
        m_lfsr = 16'h0001;
        run_steps(2, "R2 period wraps to seed");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule